// File: doc/BRIEF.md
# Gated Counter Pair with Compare-Driven Trigger

This block holds two 16-bit up-counters that run from one clock and one shared prescale divisor. The first counter, the leader, compares its count against a threshold. The result is a level that is high while the count is below the threshold and the leader is running. A selector can route that level, or one of two other leader events, onto the trigger output.

The second counter, the follower, picks its trigger from a source selector. In gated mode it advances only while that trigger is high and holds its count while the trigger is low. Each edge of the trigger in gated mode sets a sticky flag. The flag stays set until a clear strobe arrives.

Software sets up both counters through plain control ports:
- a run enable for each counter;
- a reinitialise strobe that clears the count and the prescale phase;
- a load strobe that presets the count;
- a period value at which the count wraps.

Stopping the leader drops the compare level, so the follower freezes as well.

Top module: `gated_timer_pair`

## Requirements
- R1: After synchronous reset both counts are 0, the trigger flag is 0, and the compare level is 0.
- R2: A running counter advances once per `tick_div`+1 clocks. A counter that is not running, or is gated off, keeps both its count and its prescale phase.
- R3: On a tick at a count equal to the counter's period value, the count returns to 0.
- R4: A reinitialise strobe clears the count and the prescale phase on the next edge. It takes priority over a load and over counting in the same cycle.
- R5: A load strobe (without reinitialise) writes the load value into the count on the next edge. Counting resumes from that value.
- R6: `cmp_ref` is 1 exactly when `mst_run` is 1 and `mst_cnt` < `mst_cmp`. It is 0 whenever the leader is stopped.
- R7: `trg_out` follows `mst_sel`:
  - 3'b000 gives the leader's reinitialise strobe;
  - 3'b001 gives `mst_run`;
  - 3'b100 gives `cmp_ref`;
  - any other code gives 0.
- R8: With `trg_src` = 3'b000 the follower's trigger is `trg_out`. Any other code holds the follower's trigger at 0.
- R9: With `slv_mode` = 3'b101 (gated), the follower advances only when `slv_run` is 1 and its trigger is 1. Otherwise it holds its count.
- R10: With any `slv_mode` other than 3'b101, the follower advances whenever `slv_run` is 1, whatever its trigger.
- R11: In gated mode, a rise or a fall of the follower's trigger sets `trig_flag` on the next clock edge. The flag stays set until a cycle with `flag_clr` = 1 and no new edge clears it.
- R12: In gated mode with the compare level routed to the follower, clearing `mst_run` stops the follower's counting.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_div | input | 16 | Shared prescale divisor minus one |
| mst_run | input | 1 | Leader run enable |
| mst_reinit | input | 1 | Leader reinitialise strobe |
| mst_load | input | 1 | Leader count load strobe |
| mst_load_val | input | 16 | Leader value to load |
| mst_period | input | 16 | Leader wrap value |
| mst_cmp | input | 16 | Leader compare threshold |
| mst_sel | input | 3 | Leader trigger output selector |
| slv_run | input | 1 | Follower run enable |
| slv_reinit | input | 1 | Follower reinitialise strobe |
| slv_load | input | 1 | Follower count load strobe |
| slv_load_val | input | 16 | Follower value to load |
| slv_period | input | 16 | Follower wrap value |
| trg_src | input | 3 | Follower trigger source selector |
| slv_mode | input | 3 | Follower mode: 3'b101 gated, others free |
| flag_clr | input | 1 | Clear strobe for the trigger flag |
| mst_cnt | output | 16 | Leader count |
| slv_cnt | output | 16 | Follower count |
| cmp_ref | output | 1 | Leader compare level |
| trg_out | output | 1 | Leader trigger output |
| trig_flag | output | 1 | Sticky follower trigger-edge flag |

## Verification
The hold properties assume that mode, source and selector fields change only in cycles where the follower's reinitialise or load strobe, or a stopped leader, makes the outcome clear. The stimulus meets this by changing configuration at falling edges while the counters are stopped or being reinitialised. Strobes are single-cycle pulses driven on the falling edge, so every property sees stable inputs at the rising edge. The load check assumes reinitialise and load are not raised together unless priority is the point of the test, and the stimulus never raises them together on the follower.

// File: rtl/gtp_pkg.sv
`timescale 1ns/1ps
package gtp_pkg;

    localparam int CNT_W = 16;
    localparam int DIV_W = 16;

    // leader trigger output selector codes
    typedef enum logic [2:0] {
        MSEL_REINIT = 3'b000,
        MSEL_RUN    = 3'b001,
        MSEL_CMP    = 3'b100
    } mst_sel_e;

    // follower trigger source code that picks the leader
    typedef enum logic [2:0] {
        TSRC_LEADER = 3'b000
    } trg_src_e;

    // follower mode codes
    typedef enum logic [2:0] {
        SMODE_FREE  = 3'b000,
        SMODE_GATED = 3'b101
    } slv_mode_e;

    typedef struct packed {
        logic             run;
        logic             reinit;
        logic             load;
        logic [CNT_W-1:0] load_val;
        logic [CNT_W-1:0] period;
    } cnt_ctl_t;

    function automatic logic cmp_level(input logic run,
                                       input logic [CNT_W-1:0] cnt,
                                       input logic [CNT_W-1:0] thr);
        return run && (cnt < thr);
    endfunction

endpackage

// File: rtl/gtp_counter.sv
`timescale 1ns/1ps
module gtp_counter
    import gtp_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          reinit,
    input  logic          load,
    input  logic [W-1:0]  load_val,
    input  logic [W-1:0]  period,
    input  logic [DW-1:0] div,
    output logic [W-1:0]  cnt
);
    logic [DW-1:0] phase;
    logic          tick;

    assign tick = run && (phase == div);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            phase <= '0;
        end else if (reinit) begin
            cnt   <= '0;
            phase <= '0;
        end else if (load) begin
            cnt   <= load_val;
        end else if (run) begin
            if (tick) begin
                phase <= '0;
                cnt   <= (cnt == period) ? '0 : cnt + 1'b1;
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end
endmodule

// File: rtl/gtp_trig_route.sv
`timescale 1ns/1ps
module gtp_trig_route
    import gtp_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         mst_run,
    input  logic         mst_reinit,
    input  logic [W-1:0] mst_cnt,
    input  logic [W-1:0] mst_cmp,
    input  logic [2:0]   mst_sel,
    input  logic [2:0]   trg_src,
    output logic         cmp_ref,
    output logic         trg_out,
    output logic         slv_trig
);
    always_comb begin
        cmp_ref = cmp_level(mst_run, mst_cnt, mst_cmp);
        case (mst_sel)
            MSEL_REINIT: trg_out = mst_reinit;
            MSEL_RUN:    trg_out = mst_run;
            MSEL_CMP:    trg_out = cmp_ref;
            default:     trg_out = 1'b0;
        endcase
        slv_trig = (trg_src == TSRC_LEADER) ? trg_out : 1'b0;
    end
endmodule

// File: rtl/gtp_gate_flag.sv
`timescale 1ns/1ps
module gtp_gate_flag
    import gtp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] slv_mode,
    input  logic       slv_run,
    input  logic       trig,
    input  logic       flag_clr,
    output logic       cnt_en,
    output logic       trig_flag
);
    logic trig_q;
    logic gated;

    assign gated  = (slv_mode == SMODE_GATED);
    assign cnt_en = slv_run && (!gated || trig);

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q    <= 1'b0;
            trig_flag <= 1'b0;
        end else begin
            trig_q <= trig;
            if (gated && (trig != trig_q))
                trig_flag <= 1'b1;
            else if (flag_clr)
                trig_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/gated_timer_pair.sv
`timescale 1ns/1ps
module gated_timer_pair
    import gtp_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] tick_div,
    input  logic          mst_run,
    input  logic          mst_reinit,
    input  logic          mst_load,
    input  logic [W-1:0]  mst_load_val,
    input  logic [W-1:0]  mst_period,
    input  logic [W-1:0]  mst_cmp,
    input  logic [2:0]    mst_sel,
    input  logic          slv_run,
    input  logic          slv_reinit,
    input  logic          slv_load,
    input  logic [W-1:0]  slv_load_val,
    input  logic [W-1:0]  slv_period,
    input  logic [2:0]    trg_src,
    input  logic [2:0]    slv_mode,
    input  logic          flag_clr,
    output logic [W-1:0]  mst_cnt,
    output logic [W-1:0]  slv_cnt,
    output logic          cmp_ref,
    output logic          trg_out,
    output logic          trig_flag
);
    localparam int NTMR = 2;

    logic          slv_trig;
    logic          slv_en;
    logic [W-1:0]  cnt_q   [NTMR];
    logic          run_v   [NTMR];
    logic          rein_v  [NTMR];
    logic          load_v  [NTMR];
    logic [W-1:0]  lval_v  [NTMR];
    logic [W-1:0]  per_v   [NTMR];

    assign run_v[0]  = mst_run;
    assign rein_v[0] = mst_reinit;
    assign load_v[0] = mst_load;
    assign lval_v[0] = mst_load_val;
    assign per_v[0]  = mst_period;
    assign run_v[1]  = slv_en;
    assign rein_v[1] = slv_reinit;
    assign load_v[1] = slv_load;
    assign lval_v[1] = slv_load_val;
    assign per_v[1]  = slv_period;

    for (genvar i = 0; i < NTMR; i++) begin : g_tmr
        gtp_counter #(.W(W), .DW(DW)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .run      (run_v[i]),
            .reinit   (rein_v[i]),
            .load     (load_v[i]),
            .load_val (lval_v[i]),
            .period   (per_v[i]),
            .div      (tick_div),
            .cnt      (cnt_q[i])
        );
    end

    assign mst_cnt = cnt_q[0];
    assign slv_cnt = cnt_q[1];

    gtp_trig_route #(.W(W)) u_route (
        .mst_run    (mst_run),
        .mst_reinit (mst_reinit),
        .mst_cnt    (cnt_q[0]),
        .mst_cmp    (mst_cmp),
        .mst_sel    (mst_sel),
        .trg_src    (trg_src),
        .cmp_ref    (cmp_ref),
        .trg_out    (trg_out),
        .slv_trig   (slv_trig)
    );

    gtp_gate_flag u_gate (
        .clk       (clk),
        .rst       (rst),
        .slv_mode  (slv_mode),
        .slv_run   (slv_run),
        .trig      (slv_trig),
        .flag_clr  (flag_clr),
        .cnt_en    (slv_en),
        .trig_flag (trig_flag)
    );
endmodule

// File: rtl/gtp_checker.sv
`timescale 1ns/1ps
module gtp_checker
    import gtp_pkg::*;
#(
    parameter int W = CNT_W
) (
    input logic         clk,
    input logic         rst,
    input logic         mst_run,
    input logic         mst_reinit,
    input logic [2:0]   mst_sel,
    input logic         slv_reinit,
    input logic         slv_load,
    input logic [W-1:0] slv_load_val,
    input logic [2:0]   trg_src,
    input logic [2:0]   slv_mode,
    input logic         flag_clr,
    input logic [W-1:0] mst_cnt,
    input logic [W-1:0] slv_cnt,
    input logic         cmp_ref,
    input logic         trig_flag,
    input logic         slv_trig
);
    p_ref_off_r6: assert property (@(posedge clk) disable iff (rst)
        !mst_run |-> !cmp_ref);

    p_reinit_clear_r4: assert property (@(posedge clk) disable iff (rst)
        mst_reinit |=> (mst_cnt == '0));

    p_load_value_r5: assert property (@(posedge clk) disable iff (rst)
        (slv_load && !slv_reinit) |=> (slv_cnt == $past(slv_load_val)));

    p_gate_hold_r9: assert property (@(posedge clk) disable iff (rst)
        ((slv_mode == SMODE_GATED) && !slv_trig && !slv_reinit && !slv_load)
        |=> $stable(slv_cnt));

    p_src_block_r8: assert property (@(posedge clk) disable iff (rst)
        (trg_src != TSRC_LEADER) |-> !slv_trig);

    p_flag_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (trig_flag && !flag_clr) |=> trig_flag);

    p_leader_stop_r12: assert property (@(posedge clk) disable iff (rst)
        ((slv_mode == SMODE_GATED) && (mst_sel == MSEL_CMP) &&
         (trg_src == TSRC_LEADER) && !mst_run && !slv_reinit && !slv_load)
        |=> $stable(slv_cnt));
endmodule

bind gated_timer_pair gtp_checker #(.W(W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mst_run      (mst_run),
    .mst_reinit   (mst_reinit),
    .mst_sel      (mst_sel),
    .slv_reinit   (slv_reinit),
    .slv_load     (slv_load),
    .slv_load_val (slv_load_val),
    .trg_src      (trg_src),
    .slv_mode     (slv_mode),
    .flag_clr     (flag_clr),
    .mst_cnt      (mst_cnt),
    .slv_cnt      (slv_cnt),
    .cmp_ref      (cmp_ref),
    .trig_flag    (trig_flag),
    .slv_trig     (slv_trig)
);

// File: tb/gated_timer_pair_tb.sv
`timescale 1ns/1ps
module gated_timer_pair_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] tick_div;
    logic        mst_run, mst_reinit, mst_load;
    logic [15:0] mst_load_val, mst_period, mst_cmp;
    logic [2:0]  mst_sel;
    logic        slv_run, slv_reinit, slv_load;
    logic [15:0] slv_load_val, slv_period;
    logic [2:0]  trg_src, slv_mode;
    logic        flag_clr;
    logic [15:0] mst_cnt, slv_cnt;
    logic        cmp_ref, trg_out, trig_flag;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    gated_timer_pair u_dut (
        .clk(clk), .rst(rst), .tick_div(tick_div),
        .mst_run(mst_run), .mst_reinit(mst_reinit), .mst_load(mst_load),
        .mst_load_val(mst_load_val), .mst_period(mst_period), .mst_cmp(mst_cmp),
        .mst_sel(mst_sel), .slv_run(slv_run), .slv_reinit(slv_reinit),
        .slv_load(slv_load), .slv_load_val(slv_load_val), .slv_period(slv_period),
        .trg_src(trg_src), .slv_mode(slv_mode), .flag_clr(flag_clr),
        .mst_cnt(mst_cnt), .slv_cnt(slv_cnt), .cmp_ref(cmp_ref),
        .trg_out(trg_out), .trig_flag(trig_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // advance n rising edges, return at the following falling edge
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 leader count", mst_cnt, 0);
        chk("R1 follower count", slv_cnt, 0);
        chk("R1 flag", trig_flag, 0);
        chk("R1 compare level", cmp_ref, 0);
    endtask

    task automatic t_count_wrap;
        mst_period = 16'd9; mst_cmp = 16'd4; mst_run = 1'b1;
        step(13);
        chk("R3 leader wrap count", mst_cnt, 3);
        mst_run = 1'b0;
        step(2);
        chk("R2 leader holds when stopped", mst_cnt, 3);
        chk("R6 level low while stopped", cmp_ref, 0);
        mst_run = 1'b1; #1;
        chk("R6 level high below threshold", cmp_ref, 1);
        mst_run = 1'b0;
    endtask

    task automatic t_reinit;
        mst_run = 1'b1; mst_reinit = 1'b1; mst_load = 1'b1; mst_load_val = 16'h0055;
        step(1);
        chk("R4 reinit beats run and load", mst_cnt, 0);
        mst_reinit = 1'b0; mst_load = 1'b0; mst_run = 1'b0;
    endtask

    task automatic t_prescale;
        tick_div = 16'd2; mst_run = 1'b1;
        step(9);
        chk("R2 divided count after 9", mst_cnt, 3);
        step(1);
        chk("R2 no tick mid-period", mst_cnt, 3);
        // leave prescale phase mid-way, then reinitialise while stopped
        mst_run = 1'b0; mst_reinit = 1'b1;
        step(1);
        mst_reinit = 1'b0; mst_run = 1'b1;
        step(1);
        chk("R4 prescale phase cleared", mst_cnt, 0);
        step(2);
        chk("R4 first tick after full period", mst_cnt, 1);
        mst_run = 1'b0; tick_div = 16'd0;
        mst_reinit = 1'b1; step(1); mst_reinit = 1'b0;
    endtask

    task automatic t_load;
        slv_load = 1'b1; slv_load_val = 16'h00E7;
        step(1);
        slv_load = 1'b0;
        chk("R5 follower loaded", slv_cnt, 16'h00E7);
    endtask

    task automatic t_gated;
        mst_sel = 3'b100; trg_src = 3'b000; slv_mode = 3'b101; slv_run = 1'b1;
        mst_reinit = 1'b1;
        step(1);
        mst_reinit = 1'b0;
        step(2);
        chk("R9 follower holds with gate low", slv_cnt, 16'h00E7);
        chk("R11 no edge no flag", trig_flag, 0);
        mst_run = 1'b1;
        step(1);
        chk("R11 flag on rising edge", trig_flag, 1);
        chk("R9 follower counts with gate high", slv_cnt, 16'h00E8);
        chk("R7 compare level on trigger", trg_out, 1);
        flag_clr = 1'b1;
        step(1);
        flag_clr = 1'b0;
        chk("R11 flag cleared", trig_flag, 0);
        step(2);
        chk("R11 flag stays clear", trig_flag, 0);
        step(1);
        chk("R11 flag on falling edge", trig_flag, 1);
        step(15);
        chk("R9 follower counts only gate-high cycles", slv_cnt, 16'h00EF);
        chk("R3 leader back to zero", mst_cnt, 0);
    endtask

    task automatic t_stop;
        mst_run = 1'b0;
        step(5);
        chk("R12 follower frozen after leader stop", slv_cnt, 16'h00EF);
    endtask

    task automatic t_source;
        trg_src = 3'b001; mst_run = 1'b1;
        step(10);
        chk("R8 other source blocks gate", slv_cnt, 16'h00EF);
        mst_run = 1'b0; trg_src = 3'b000;
    endtask

    task automatic t_free;
        slv_mode = 3'b000;
        step(5);
        chk("R10 free mode ignores trigger", slv_cnt, 16'h00F4);
        slv_run = 1'b0;
        step(3);
        chk("R10 free mode holds when stopped", slv_cnt, 16'h00F4);
    endtask

    task automatic t_select;
        mst_sel = 3'b001; mst_run = 1'b1; #1;
        chk("R7 run select high", trg_out, 1);
        mst_run = 1'b0; #1;
        chk("R7 run select low", trg_out, 0);
        mst_sel = 3'b010; mst_run = 1'b1; #1;
        chk("R7 unused select gives 0", trg_out, 0);
        mst_run = 1'b0; mst_sel = 3'b000; mst_reinit = 1'b1; #1;
        chk("R7 reinit select", trg_out, 1);
        step(1);
        mst_reinit = 1'b0;
    endtask

    task automatic t_slv_wrap;
        slv_period = 16'h00F5; slv_run = 1'b1;
        step(3);
        chk("R3 follower wrap", slv_cnt, 1);
        slv_run = 1'b0;
    endtask

    initial begin
        rst = 1'b1; tick_div = '0;
        mst_run = 0; mst_reinit = 0; mst_load = 0; mst_load_val = '0;
        mst_period = 16'hFFFF; mst_cmp = '0; mst_sel = 3'b000;
        slv_run = 0; slv_reinit = 0; slv_load = 0; slv_load_val = '0;
        slv_period = 16'hFFFF; trg_src = 3'b000; slv_mode = 3'b000; flag_clr = 0;
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_count_wrap();
        t_reinit();
        t_prescale();
        t_load();
        t_gated();
        t_stop();
        t_source();
        t_free();
        t_select();
        t_slv_wrap();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule